// File: doc/BRIEF.md
# XOR Test Pattern with Run-Time Line Selection

This block paints an XOR test image for a VGA output stage. Each visible pixel's 8-bit intensity is the low byte of the pixel column XORed with an effective line number. That same intensity goes to all three colour channels, giving a 24-bit word for the DACs. The effective line number is a separate 8-bit counter, not the raw vertical position. It can start at one of eight preset values and can be moved to almost any line while the image is running.

While reset is held low, the block reads an 8-bit configuration byte on every clock. The value present on the last clock of reset is the one kept. That byte picks:
- a timing-mode flag that is passed out to the sync generator;
- the display mode;
- a 3-bit preset start line;
- whether the colour word leaves through a flip-flop stage or straight from the logic.

On each falling edge of horizontal sync that ends a visible line, the byte is read again. It either lets the counter step by one or loads a new line number packed into the byte. A falling edge of vertical sync puts the counter back to the preset start line for the next frame. The timing counters and sync strobes come from an external generator.

Top module: `xor_line_pattern`

## Requirements
- R1: While rst_n is low, cfg_byte is captured on every rising clock edge, and the value of the last edge before release is kept. Its fields are: bit 7 timing flag, bits 6:4 display mode, bits 3:1 start code, bit 0 output registering.
- R2: On leaving reset, line_num equals the start line selected by bits 3:1: 0→0, 1→1, 2→2, 3→3, 4→8, 5→32, 6→127, 7→192.
- R3: On a clock where hsync_n is sampled low after being high, with vpos below the visible height, a byte whose bits 6:4 are 011 makes line_num step by one, modulo 256 (255 steps to 0).
- R4: On the same kind of edge with bits 6:4 not 011, line_num loads {bit7, bits 3:0, bits 6:4 XOR 011}. For example, 00100000 gives 1, 01001111 gives 127, 10100000 gives 129 and 11001111 gives 255.
- R5: A horizontal sync falling edge while vpos is at or beyond the visible height leaves line_num unchanged.
- R6: A vertical sync falling edge (vsync_n high then low) reloads line_num with the preset start line, and it wins over a simultaneous horizontal event.
- R7: In display mode 011, a visible pixel (hpos < 640 and vpos < 480) gives rgb = {p,p,p}, where p = hpos[7:0] XOR line_num.
- R8: Outside the visible area, rgb is zero.
- R9: When the captured display mode is not 011, rgb is zero everywhere.
- R10: With bit 0 set, rgb follows its inputs one clock later through a register. With bit 0 clear, it follows them within the same cycle.
- R11: timing_sel presents the captured bit 7.
- R12: With no sync falling edge, line_num holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is sampled while low |
| cfg_byte | input | 8 | Configuration byte at reset; line command at horizontal sync |
| hpos | input | CW | Horizontal pixel counter |
| vpos | input | CW | Vertical line counter |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| rgb | output | 24 | Colour word {R,G,B} for the DACs |
| line_num | output | 8 | Effective line number |
| timing_sel | output | 1 | Captured timing-mode flag |

## Verification
The bench targets the packed jump codes whose low bits must be unscrambled. A design that forgot the XOR would land on the wrong line. One that let a non-continue code step the counter would draw line+1 instead of the requested line. Wraparound from 255 to 0, horizontal events during vertical blanking, and a vertical edge that coincides with a horizontal one are each driven directly. Miscounting there shows up as a shifted or frozen picture. The registered path is probed by changing the column mid-stream: an output that skipped the flop would show the new pixel one cycle early.

// File: rtl/xor_line_pattern.sv
module xor_line_pattern #(
  parameter int CW    = 10,
  parameter int H_VIS = 640,
  parameter int V_VIS = 480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_byte,
  input  logic [CW-1:0] hpos,
  input  logic [CW-1:0] vpos,
  input  logic          hsync_n,
  input  logic          vsync_n,
  output logic [23:0]   rgb,
  output logic [7:0]    line_num,
  output logic          timing_sel
);

  localparam logic [2:0]    XOR_MODE = 3'b011;
  localparam logic [CW-1:0] H_LIM    = CW'(H_VIS);
  localparam logic [CW-1:0] V_LIM    = CW'(V_VIS);

  logic [7:0]  cfg_q;
  logic [7:0]  line_q;
  logic        hs_d, vs_d;
  logic [23:0] rgb_q;
  logic [23:0] rgb_next;

  function automatic logic [7:0] start_line(input logic [2:0] code);
    case (code)
      3'd0:    return 8'd0;
      3'd1:    return 8'd1;
      3'd2:    return 8'd2;
      3'd3:    return 8'd3;
      3'd4:    return 8'd8;
      3'd5:    return 8'd32;
      3'd6:    return 8'd127;
      default: return 8'd192;
    endcase
  endfunction

  wire [7:0] start_val = start_line(cfg_q[3:1]);
  wire       hs_ev     = hs_d & ~hsync_n;
  wire       vs_ev     = vs_d & ~vsync_n;
  wire       vis_line  = vpos < V_LIM;
  wire       visible   = vis_line && (hpos < H_LIM);
  wire       cont      = cfg_byte[6:4] == XOR_MODE;
  wire [7:0] jump      = {cfg_byte[7], cfg_byte[3:0], cfg_byte[6:4] ^ XOR_MODE};
  wire [7:0] pix       = hpos[7:0] ^ line_q;

  assign rgb_next = (visible && cfg_q[6:4] == XOR_MODE) ? {pix, pix, pix} : 24'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= cfg_byte;
      line_q <= start_line(cfg_byte[3:1]);
      hs_d   <= hsync_n;
      vs_d   <= vsync_n;
      rgb_q  <= 24'd0;
    end else begin
      hs_d  <= hsync_n;
      vs_d  <= vsync_n;
      rgb_q <= rgb_next;
      if (vs_ev)
        line_q <= start_val;
      else if (hs_ev && vis_line)
        line_q <= cont ? line_q + 8'd1 : jump;
    end
  end

  assign rgb        = cfg_q[0] ? rgb_q : rgb_next;
  assign line_num   = line_q;
  assign timing_sel = cfg_q[7];

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_ev && !vs_ev) |=> $stable(line_num)); // R12

  AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ev && !vs_ev && vis_line && cont) |=> line_num == $past(line_num) + 8'd1); // R3

  AST_VBLANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ev && !vs_ev && !vis_line) |=> $stable(line_num)); // R5

  AST_VS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    vs_ev |=> line_num == start_line(cfg_q[3:1])); // R6

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[0] && !visible) |-> rgb == 24'd0); // R8

  AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[0] |=> rgb == $past(rgb_next)); // R10

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(timing_sel)); // R11

endmodule

// File: tb/tb_xor_line_pattern.sv
module tb_xor_line_pattern;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_byte = 8'h30;
  logic [9:0]  hpos = '0;
  logic [9:0]  vpos = '0;
  logic        hsync_n = 1'b1;
  logic        vsync_n = 1'b1;
  logic [23:0] rgb;
  logic [7:0]  line_num;
  logic        timing_sel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] m_cfg;
  logic [7:0] m_line;

  always #4 clk = ~clk;

  xor_line_pattern dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .hpos(hpos), .vpos(vpos),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb), .line_num(line_num),
    .timing_sel(timing_sel)
  );

  function automatic logic [7:0] start_of(input logic [2:0] c);
    logic [7:0] t [8] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd8, 8'd32, 8'd127, 8'd192};
    return t[c];
  endfunction

  function automatic logic [7:0] after_hs(input logic [7:0] b, input logic [7:0] l);
    if (b[6:4] == 3'b011) return l + 8'd1;
    return {b[7], b[3:0], b[6:4] ^ 3'b011};
  endfunction

  function automatic logic [23:0] exp_rgb(input logic [9:0] hp, input logic [9:0] vp);
    logic [7:0] p;
    p = hp[7:0] ^ m_line;
    if (hp < 10'd640 && vp < 10'd480 && m_cfg[6:4] == 3'b011) return {p, p, p};
    return 24'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] b);
    @(negedge clk);
    rst_n = 1'b0; hsync_n = 1'b1; vsync_n = 1'b1;
    cfg_byte = ~b;
    @(negedge clk);
    cfg_byte = b;
    @(negedge clk);
    rst_n = 1'b1;
    m_cfg = b;
    m_line = start_of(b[3:1]);
    check("R2 start line", line_num, m_line);
    check("R11 timing flag", timing_sel, b[7]);
    @(negedge clk);
    check("R1 last reset byte kept", line_num, m_line);
  endtask

  task automatic hs(input logic [7:0] b, input logic [9:0] vp);
    cfg_byte = b; vpos = vp; hsync_n = 1'b0;
    @(negedge clk);
    if (vp < 10'd480) m_line = after_hs(b, m_line);
    if (vp >= 10'd480) check("R5 vblank hsync ignored", line_num, m_line);
    else if (b[6:4] == 3'b011) check("R3 continue", line_num, m_line);
    else check("R4 jump decode", line_num, m_line);
    hsync_n = 1'b1;
    @(negedge clk);
    check("R12 line holds", line_num, m_line);
  endtask

  task automatic vs(input logic with_hs, input logic [7:0] b);
    cfg_byte = b; vpos = 10'd10; vsync_n = 1'b0; hsync_n = ~with_hs;
    @(negedge clk);
    m_line = start_of(m_cfg[3:1]);
    check("R6 vsync reload", line_num, m_line);
    vsync_n = 1'b1; hsync_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic px(input logic [9:0] hp, input logic [9:0] vp, input string req);
    hpos = hp; vpos = vp;
    @(negedge clk);
    check(req, rgb, exp_rgb(hp, vp));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    for (int c = 0; c < 8; c++) do_reset({c[0], 3'b011, c[2:0], c[1]});
    do_reset(8'b0_011_000_0);
    hs(8'b0010_0000, 10'd5);
    hs(8'b0000_0000, 10'd5);
    hs(8'b0111_0000, 10'd5);
    hs(8'b0100_0000, 10'd5);
    hs(8'b0010_0001, 10'd5);
    hs(8'b1010_0000, 10'd5);
    hs(8'b0011_0001, 10'd5);
    hs(8'b0100_1111, 10'd5);
    check("R4 line 127", line_num, 8'd127);
    hs(8'b1011_0101, 10'd6);
    hs(8'b0011_0000, 10'd7);
    check("R3 127 then 129", line_num, 8'd129);
    hs(8'b1100_1111, 10'd8);
    hs(8'b0011_1111, 10'd9);
    check("R3 wrap to 0", line_num, 8'd0);
    hs(8'b0100_0000, 10'd480);
    hs(8'b0100_0000, 10'd520);
    vs(1'b1, 8'b0100_0000);
    vs(1'b0, 8'b0011_0000);
    px(10'd5, 10'd3, "R7 pattern");
    px(10'd300, 10'd479, "R7 pattern");
    px(10'd640, 10'd3, "R8 blank h");
    px(10'd10, 10'd480, "R8 blank v");

    do_reset(8'b1_011_110_1);
    hpos = 10'd17; vpos = 10'd2;
    @(negedge clk);
    check("R10 registered", rgb, exp_rgb(10'd17, 10'd2));
    hpos = 10'd18; #1;
    check("R10 registered delay", rgb, exp_rgb(10'd17, 10'd2));
    @(negedge clk);
    check("R10 registered next", rgb, exp_rgb(10'd18, 10'd2));
    do_reset(8'b0_011_010_0);
    hpos = 10'd40; #1;
    check("R10 unregistered", rgb, exp_rgb(10'd40, vpos));

    do_reset(8'b1_000_010_0);
    px(10'd5, 10'd3, "R9 other mode");
    px(10'd100, 10'd100, "R9 other mode");

    for (int s = 0; s < 4; s++) begin
      do_reset({s[0], 3'b011, 1'(s), 2'(s + 1), s[1]});
      for (int i = 0; i < 500; i++) begin
        int r;
        r = int'($urandom % 10);
        if (r < 4) hs(8'($urandom), 10'($urandom % 525));
        else if (r == 4) vs(1'($urandom), 8'($urandom));
        else px(10'($urandom % 800), 10'($urandom % 525), "R7/R8 random");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule